// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between an on-chip requester and an external asynchronous static RAM with a 16-bit data path split into two byte lanes. The requester offers one access at a time through a valid/ready handshake that carries an address, write data, a direction flag and a two-bit lane mask. The block then plays out the memory's control waveform: active-low chip select, write strobe, output enable and one enable per byte lane. Each phase lasts a whole number of clock cycles, and each of those counts is a parameter. The designer picks them by rounding the memory's nanosecond limits up to clock periods.

A write has two phases. First comes a setup phase, with the chip and the lanes selected and the write strobe still high. Then the strobe goes low for the pulse width. The block drives the data bus from the second cycle of that pulse until the strobe rises, so the memory's output drivers have a full cycle to turn off before the block drives. With `WR_OE_LOW` set, output enable stays low for the whole write; this is the strobe-controlled style of write. A read holds chip select and output enable low with the strobe high for the access count. It samples the bus on the last of those cycles and returns the data with a one-cycle valid pulse, with lanes that were not requested set to zero. Every access ends with a turnaround phase in which all controls are released, and only then does ready return.

Top module: `sram_async_ctrl`

## Requirements
- R1: While idle and during reset, chip select, write strobe, output enable and both lane enables are high, the data bus is not driven, and `req_ready` is high.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is then low for exactly SETUP_CYC+WE_CYC+TURN_CYC cycles after a write and RD_CYC+TURN_CYC cycles after a read.
- R3: A write first holds chip select low with the write strobe high for SETUP_CYC cycles. It then holds the strobe low for WE_CYC cycles. The address stays stable while chip select is low.
- R4: `mem_dout_oe` is high only while the write strobe is low. It is high on every strobe-low cycle except the first, so it is still high on the last cycle before the strobe rises.
- R5: Mask bit 0 selects lane enable 0 (data bits 7:0) and mask bit 1 selects lane enable 1 (bits 15:8). A lane enable is low during an access only if its mask bit is 1, so a write changes only the selected lanes and a write with mask 00 changes nothing.
- R6: A read holds chip select and output enable low with the strobe high for RD_CYC cycles. The bus is sampled at the end of the last of those cycles, and `rd_valid` is high for exactly one cycle, the next one, with `rd_data` holding the sample.
- R7: In `rd_data`, every byte whose mask bit was 0 reads as zero.
- R8: With WR_OE_LOW = 1, output enable stays low through the setup and strobe phases of a write. The block never drives the bus in a cycle where the memory is enabled to drive it (chip select low, output enable low, strobe high).
- R9: After every access, chip select, output enable, the strobe and both lane enables are high for TURN_CYC cycles before `req_ready` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| req_mask | input | NB | Lane mask, bit i selects bits 8i+7:8i |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | DW | Read data, unselected lanes zero |
| mem_addr | output | AW | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | NB | Lane enables, active low |
| mem_dout | output | DW | Data toward memory |
| mem_dout_oe | output | 1 | Block drives the data bus |
| mem_din | input | DW | Data bus as seen from memory |

## Verification
The hardest case to reach from the ports is a late or early sample inside the read window. A memory that answered at once would hide a sampling cycle off by one. The bench's memory model therefore returns junk until output enable has been held for the full access count, and it puts junk on any lane whose enable is high. The model also checks for bus contention on every cycle of the strobe-controlled writes. It stores only what is on the bus while the strobe is low and the block is driving, so a data-drive window that closes early shows up as wrong data on readback.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int AW        = 18,
  parameter int DW        = 16,
  parameter int NB        = DW / 8,
  parameter int SETUP_CYC = 1,
  parameter int WE_CYC    = 2,
  parameter int RD_CYC    = 2,
  parameter int TURN_CYC  = 1,
  parameter bit WR_OE_LOW = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [NB-1:0] req_mask,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [NB-1:0] mem_be_n,
  output logic [DW-1:0] mem_dout,
  output logic          mem_dout_oe,
  input  logic [DW-1:0] mem_din
);

  localparam int M1   = (SETUP_CYC > WE_CYC) ? SETUP_CYC : WE_CYC;
  localparam int M2   = (RD_CYC > TURN_CYC) ? RD_CYC : TURN_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_SET, S_PULSE, S_READ, S_TURN} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] a_q;
  logic [DW-1:0] d_q;
  logic [NB-1:0] m_q;
  logic [DW-1:0] lane_keep;
  logic          active;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign lane_keep[8*i +: 8] = {8{m_q[i]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      a_q      <= '0;
      d_q      <= '0;
      m_q      <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          a_q <= req_addr;
          d_q <= req_wdata;
          m_q <= req_mask;
          if (req_write) begin
            st  <= S_SET;
            cnt <= CW'(SETUP_CYC - 1);
          end else begin
            st  <= S_READ;
            cnt <= CW'(RD_CYC - 1);
          end
        end
        S_SET: if (cnt == '0) begin
          st  <= S_PULSE;
          cnt <= CW'(WE_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_PULSE: if (cnt == '0) begin
          st  <= S_TURN;
          cnt <= CW'(TURN_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_READ: if (cnt == '0) begin
          rd_data  <= mem_din & lane_keep;
          rd_valid <= 1'b1;
          st       <= S_TURN;
          cnt      <= CW'(TURN_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_TURN: if (cnt == '0) st <= S_IDLE;
                else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign active      = (st == S_SET) || (st == S_PULSE) || (st == S_READ);
  assign req_ready   = (st == S_IDLE);
  assign mem_addr    = a_q;
  assign mem_dout    = d_q;
  assign mem_ce_n    = !active;
  assign mem_we_n    = (st != S_PULSE);
  assign mem_oe_n    = !((st == S_READ) || (WR_OE_LOW && (st == S_SET || st == S_PULSE)));
  assign mem_be_n    = active ? ~m_q : '1;
  assign mem_dout_oe = (st == S_PULSE) && (cnt != CW'(WE_CYC - 1));

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int AW = 18,
  parameter int NB = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rd_valid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic [NB-1:0] mem_be_n,
  input logic          mem_dout_oe
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && (&mem_be_n) && !mem_dout_oe));

  a_r2_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r3_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  a_r4_drive_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dout_oe |-> (!mem_we_n && !mem_ce_n));

  a_r4_first_cycle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !mem_dout_oe);

  a_r4_drive_to_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> $past(mem_dout_oe));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  a_r6_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!mem_ce_n && !mem_oe_n && mem_we_n));

  a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !mem_oe_n && mem_we_n) |-> !mem_dout_oe);

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.AW(AW), .NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rd_valid(rd_valid), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
  .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n),
  .mem_dout_oe(mem_dout_oe)
);

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;
  localparam int AW = 5, DW = 16, NB = 2;
  localparam int SC = 2, WC = 3, RC = 3, TC = 2;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [NB-1:0] req_mask = '0;
  logic req_ready, rd_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dout_oe;
  logic [DW-1:0] rd_data, mem_dout, mem_din;
  logic [AW-1:0] mem_addr;
  logic [NB-1:0] mem_be_n;

  int vectors = 0, fails = 0, contention = 0, acc = 0;
  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] expm [WORDS];
  logic rd_cond;

  always #2.5 clk = ~clk;

  sram_async_ctrl #(.AW(AW), .DW(DW), .NB(NB), .SETUP_CYC(SC), .WE_CYC(WC),
                    .RD_CYC(RC), .TURN_CYC(TC), .WR_OE_LOW(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dout(mem_dout),
    .mem_dout_oe(mem_dout_oe), .mem_din(mem_din));

  assign rd_cond = !mem_ce_n && !mem_oe_n && mem_we_n;

  always_comb begin
    for (int i = 0; i < NB; i++)
      mem_din[8*i +: 8] = (rd_cond && acc >= RC - 1 && !mem_be_n[i])
                          ? mem[mem_addr][8*i +: 8] : 8'hA5;
  end

  always @(posedge clk) acc <= rd_cond ? acc + 1 : 0;

  always @(negedge clk) begin
    if (!mem_ce_n && !mem_we_n && mem_dout_oe)
      for (int i = 0; i < NB; i++)
        if (!mem_be_n[i]) mem[mem_addr][8*i +: 8] <= mem_dout[8*i +: 8];
    if (rd_cond && mem_dout_oe) contention <= contention + 1;
  end

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return 16'((a * 16'h0137 + k * 16'h2F11) ^ 16'hC35A);
  endfunction

  function automatic logic [DW-1:0] lanes(input logic [NB-1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit w, input int a, input logic [DW-1:0] d,
                        input logic [NB-1:0] m);
    int busy = 0, rv = 0, rv_n = 0, bad = 0;
    logic [DW-1:0] got = '0;
    logic [5:0] pins, want;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = AW'(a); req_wdata = d; req_mask = m;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready && busy < 60) begin
      busy++;
      pins = {mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, mem_dout_oe};
      if (w) begin
        if (busy <= SC)           want = {1'b0, 1'b1, 1'b0, ~m, 1'b0};
        else if (busy <= SC + WC) want = {1'b0, 1'b0, 1'b0, ~m, busy > SC + 1};
        else                      want = 6'b111110;
      end else begin
        if (busy <= RC) want = {1'b0, 1'b1, 1'b0, ~m, 1'b0};
        else            want = 6'b111110;
      end
      if (pins != want) begin
        if (bad == 0) chk(0, w ? "R3/R4/R5/R8/R9 write pins" : "R5/R6/R9 read pins",
                          {26'd0, pins}, {26'd0, want});
        bad++;
      end
      if (rd_valid) begin rv++; rv_n = busy; got = rd_data; end
      @(negedge clk);
    end
    if (bad == 0) chk(1, "pins", 0, 0);
    chk(busy == (w ? SC + WC + TC : RC + TC), "R2 busy length", busy, w ? SC + WC + TC : RC + TC);
    if (w) begin
      chk(rv == 0, "R6 no rd_valid on write", rv, 0);
      for (int i = 0; i < NB; i++)
        if (m[i]) expm[a][8*i +: 8] = d[8*i +: 8];
    end else begin
      chk(rv == 1 && rv_n == RC + 1, "R6 rd_valid timing", rv_n, RC + 1);
      chk(got == (expm[a] & lanes(m)), "R5/R7 read data", got, expm[a] & lanes(m));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int a = 0; a < WORDS; a++) begin mem[a] = '0; expm[a] = '0; end
    repeat (3) @(negedge clk);
    chk(req_ready && mem_ce_n && mem_we_n && mem_oe_n && mem_be_n == 2'b11 && !mem_dout_oe,
        "R1 pins in reset", {26'd0, req_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dout_oe}, 5'h1F);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready && mem_ce_n && mem_we_n && mem_oe_n && mem_be_n == 2'b11 && !mem_dout_oe,
        "R1 idle after reset", {26'd0, req_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dout_oe}, 5'h1F);
    for (int a = 0; a < WORDS; a++) access(1'b1, a, pat(a, 0), 2'b11);
    for (int a = 0; a < WORDS; a++) access(1'b0, a, '0, 2'b11);
    for (int a = 0; a < WORDS; a++) access(1'b1, a, pat(a, 7), 2'(a % 4));
    for (int m = 1; m < 4; m++)
      for (int a = 0; a < WORDS; a++) access(1'b0, a, '0, 2'(m));
    access(1'b0, 5, '0, 2'b00);
    chk(contention == 0, "R8 bus contention cycles", contention, 0);
    @(negedge clk);
    chk(req_ready && mem_ce_n && mem_oe_n && !mem_dout_oe, "R1 idle at end",
        {29'd0, req_ready, mem_ce_n, mem_oe_n}, 3'b111);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule